// File: doc/BRIEF.md
# Relocatable Index/Data Register Port

This block decodes two adjacent host I/O addresses and uses them as an index/data pair that reaches a small bank of eight byte-wide registers at run time. The host writes a register number to the lower address (the index port). It then reads or writes the selected register through the next address up (the data port). The registers are plain storage. The GPIO, watchdog and power-management logic around the block read them through a flat output bus and see a write strobe and a read strobe for each register.

The pair can sit at one of four even base addresses. Configuration mode uses a separate register window with its own address space. In that window the same eight registers appear at other offsets, and one more offset holds the pending base address. A pending base written in configuration mode does not move the run-time decoder at once. The decoder keeps the old base until configuration mode is left, so the host can keep using the ports while it reprograms them. An external enable input switches the run-time ports on and off as a whole.

Top module: `idx_data_port`

## Requirements
- R1: After reset the index latch holds 0x00, all eight registers hold 0x00, and the pending and active base are both 0xEA.
- R2: The index port decodes at I/O address {zeros, activeBase} and the data port at activeBase+1. Every upper address bit above bit 7 must be zero. hostAck is 1 only for a read or write that hits one of these two addresses; any other access leaves hostRdData at 0x00.
- R3: While runAccessEn is 0, neither port acknowledges, hostRdData stays 0x00, and writes change neither the index latch nor any register.
- R4: A write to the index port stores the 8-bit data in the index latch, and a read of the index port returns the latch in the same cycle.
- R5: Through the data port, index 0x01, 0x03, 0x05, 0x06, 0x08, 0x09, 0x0A and 0x0B select register slots 0 to 7 in that order (GPIO 1, watchdog control, GPIO 5, GPIO 6, power enable 1 and 2, power status 1 and 2). Reads return the slot and writes store into it, both in the same cycle.
- R6: At any other index value, a data-port read returns 0x00 (still acknowledged) and a data-port write changes no register.
- R7: While cfgMode is 1, configuration offsets 0xF6, 0xF4, 0xF9, 0xFA and 0xB0 to 0xB3 read and write slots 0 to 7 in that order. Other offsets, and any configuration access while cfgMode is 0, read 0x00 and write nothing.
- R8: A configuration write to offset 0xEC in configuration mode sets the pending base, but only if the value is 0xE0, 0xE2, 0xE4 or 0xEA. Other values are ignored. Offset 0xEC reads back the pending base.
- R9: The active base takes the pending base at the first clock edge at which cfgMode is seen low after being high. Before that edge, including all of configuration mode and the first low cycle, the previous base decodes.
- R10: When a configuration write and a data-port write hit the same slot in one cycle, the slot takes the configuration data. When they hit different slots, both writes take effect.
- R11: regWrStb bit n is high in exactly the cycles in which slot n is written, and regRdStb bit n is high in the cycles in which slot n is read through either path. regsQ[8n+7:8n] always shows slot n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWr | input | 1 | Host I/O write strobe |
| ioRd | input | 1 | Host I/O read strobe |
| ioWdata | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data (combinational) |
| hostAck | output | 1 | Access hits the index or data port |
| runAccessEn | input | 1 | Run-time port enable |
| cfgMode | input | 1 | Configuration mode active |
| cfgWr | input | 1 | Configuration window write strobe |
| cfgRd | input | 1 | Configuration window read strobe |
| cfgAddr | input | 8 | Configuration window offset |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data (combinational) |
| regsQ | output | 64 | All eight registers, slot n at bits 8n+7:8n |
| regWrStb | output | 8 | Per-slot write strobe |
| regRdStb | output | 8 | Per-slot read strobe |

## Verification
The index map is swept over all 256 index values. A distinct data byte is written at each index and read back, which separates the eight mapped indices from their neighbours and catches aliasing between slots. The address decoder is swept over a band of addresses around the ports with a non-zero index latch, so an index hit, a data hit and a miss give three different results. Relocation is run through every legal base and one illegal base, checking at each step the old base inside configuration mode, the exit cycle and the new base after it. Simultaneous writes from both paths, to the same slot and to different slots, show the priority rule.

// File: rtl/idp_pkg.sv
package idp_pkg;
  localparam int NUM_REGS = 8;
  localparam int SLOT_W   = $clog2(NUM_REGS);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic  hit;
    slot_t slot;
  } map_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic  idxRd;
    logic  runRd;
    logic  runWr;
    slot_t runSlot;
    logic  cfgRdReg;
    logic  cfgWrReg;
    slot_t cfgSlot;
    logic  cfgRdBase;
  } strobe_t;

  // Run-time index to register slot
  function automatic map_t runIndexMap(logic [7:0] idx);
    map_t m;
    m = '0;
    m.hit = 1'b1;
    case (idx)
      8'h01:   m.slot = slot_t'(0);
      8'h03:   m.slot = slot_t'(1);
      8'h05:   m.slot = slot_t'(2);
      8'h06:   m.slot = slot_t'(3);
      8'h08:   m.slot = slot_t'(4);
      8'h09:   m.slot = slot_t'(5);
      8'h0A:   m.slot = slot_t'(6);
      8'h0B:   m.slot = slot_t'(7);
      default: m.hit  = 1'b0;
    endcase
    return m;
  endfunction

  // Configuration window offset to register slot
  function automatic map_t cfgOfsMap(logic [7:0] ofs);
    map_t m;
    m = '0;
    m.hit = 1'b1;
    case (ofs)
      8'hF6:   m.slot = slot_t'(0);
      8'hF4:   m.slot = slot_t'(1);
      8'hF9:   m.slot = slot_t'(2);
      8'hFA:   m.slot = slot_t'(3);
      8'hB0:   m.slot = slot_t'(4);
      8'hB1:   m.slot = slot_t'(5);
      8'hB2:   m.slot = slot_t'(6);
      8'hB3:   m.slot = slot_t'(7);
      default: m.hit  = 1'b0;
    endcase
    return m;
  endfunction

  function automatic logic baseLegal(logic [7:0] b);
    return (b == 8'hE0) || (b == 8'hE2) || (b == 8'hE4) || (b == 8'hEA);
  endfunction
endpackage

// File: rtl/idp_ctrl.sv
module idp_ctrl
  import idp_pkg::*;
#(
  parameter int         ADDR_W       = 16,
  parameter logic [7:0] RESET_BASE   = 8'hEA,
  parameter logic [7:0] BASE_CFG_OFS = 8'hEC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWdata,
  input  logic              runAccessEn,
  input  logic              cfgMode,
  input  logic              cfgWr,
  input  logic              cfgRd,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWdata,
  output strobe_t           stb,
  output logic              hostAck,
  output logic [7:0]        indexQ,
  output logic [7:0]        pendingBase,
  output logic [7:0]        activeBase
);
  logic       cfgModeQ;
  logic       upperZero;
  logic       idxHit;
  logic       dataHit;
  logic       modeExit;
  logic       baseWrite;
  logic [7:0] dataAddr;
  map_t       runMap;
  map_t       cfgMap;

  assign upperZero = (ioAddr[ADDR_W-1:8] == '0);
  assign dataAddr  = activeBase + 8'd1;
  assign idxHit    = runAccessEn && upperZero && (ioAddr[7:0] == activeBase);
  assign dataHit   = runAccessEn && upperZero && (ioAddr[7:0] == dataAddr);
  assign hostAck   = (ioWr || ioRd) && (idxHit || dataHit);

  assign runMap    = runIndexMap(indexQ);
  assign cfgMap    = cfgOfsMap(cfgAddr);
  assign modeExit  = cfgModeQ && !cfgMode;
  assign baseWrite = cfgMode && cfgWr && (cfgAddr == BASE_CFG_OFS) && baseLegal(cfgWdata);

  always_comb begin
    stb           = '0;
    stb.idxRd     = ioRd && idxHit;
    stb.runRd     = ioRd && dataHit && runMap.hit;
    stb.runWr     = ioWr && dataHit && runMap.hit;
    stb.runSlot   = runMap.slot;
    stb.cfgRdReg  = cfgMode && cfgRd && cfgMap.hit;
    stb.cfgWrReg  = cfgMode && cfgWr && cfgMap.hit;
    stb.cfgSlot   = cfgMap.slot;
    stb.cfgRdBase = cfgMode && cfgRd && (cfgAddr == BASE_CFG_OFS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ      <= 8'h00;
      pendingBase <= RESET_BASE;
      activeBase  <= RESET_BASE;
      cfgModeQ    <= 1'b0;
    end else begin
      cfgModeQ <= cfgMode;
      if (ioWr && idxHit) indexQ <= ioWdata;
      if (baseWrite) pendingBase <= cfgWdata;
      if (modeExit) activeBase <= pendingBase;
    end
  end
endmodule

// File: rtl/idp_datapath.sv
module idp_datapath
  import idp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [7:0]            ioWdata,
  input  logic [7:0]            cfgWdata,
  input  logic [7:0]            indexQ,
  input  logic [7:0]            pendingBase,
  output logic [7:0]            hostRdData,
  output logic [7:0]            cfgRdata,
  output logic [NUM_REGS*8-1:0] regsQ,
  output logic [NUM_REGS-1:0]   regWrStb,
  output logic [NUM_REGS-1:0]   regRdStb
);
  logic [7:0] regQ [NUM_REGS];
  logic [NUM_REGS-1:0] cfgSel;
  logic [NUM_REGS-1:0] runSel;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign cfgSel[g]        = stb.cfgWrReg && (stb.cfgSlot == slot_t'(g));
    assign runSel[g]        = stb.runWr && (stb.runSlot == slot_t'(g));
    assign regWrStb[g]      = cfgSel[g] || runSel[g];
    assign regRdStb[g]      = (stb.runRd && (stb.runSlot == slot_t'(g))) ||
                              (stb.cfgRdReg && (stb.cfgSlot == slot_t'(g)));
    assign regsQ[g*8 +: 8]  = regQ[g];
  end

  // Configuration path has priority on a shared slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= 8'h00;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (cfgSel[i])      regQ[i] <= cfgWdata;
        else if (runSel[i]) regQ[i] <= ioWdata;
      end
    end
  end

  always_comb begin
    if (stb.idxRd)      hostRdData = indexQ;
    else if (stb.runRd) hostRdData = regQ[stb.runSlot];
    else                hostRdData = 8'h00;
  end

  always_comb begin
    if (stb.cfgRdReg)       cfgRdata = regQ[stb.cfgSlot];
    else if (stb.cfgRdBase) cfgRdata = pendingBase;
    else                    cfgRdata = 8'h00;
  end
endmodule

// File: rtl/idx_data_port.sv
module idx_data_port
  import idp_pkg::*;
#(
  parameter int         ADDR_W       = 16,
  parameter logic [7:0] RESET_BASE   = 8'hEA,
  parameter logic [7:0] BASE_CFG_OFS = 8'hEC
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     ioAddr,
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic [7:0]            ioWdata,
  output logic [7:0]            hostRdData,
  output logic                  hostAck,
  input  logic                  runAccessEn,
  input  logic                  cfgMode,
  input  logic                  cfgWr,
  input  logic                  cfgRd,
  input  logic [7:0]            cfgAddr,
  input  logic [7:0]            cfgWdata,
  output logic [7:0]            cfgRdata,
  output logic [NUM_REGS*8-1:0] regsQ,
  output logic [NUM_REGS-1:0]   regWrStb,
  output logic [NUM_REGS-1:0]   regRdStb
);
  strobe_t    stb;
  logic [7:0] indexQ;
  logic [7:0] pendingBase;
  logic [7:0] activeBase;

  idp_ctrl #(
    .ADDR_W(ADDR_W), .RESET_BASE(RESET_BASE), .BASE_CFG_OFS(BASE_CFG_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .runAccessEn(runAccessEn), .cfgMode(cfgMode),
    .cfgWr(cfgWr), .cfgRd(cfgRd), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .stb(stb), .hostAck(hostAck), .indexQ(indexQ),
    .pendingBase(pendingBase), .activeBase(activeBase)
  );

  idp_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ioWdata(ioWdata), .cfgWdata(cfgWdata),
    .indexQ(indexQ), .pendingBase(pendingBase), .hostRdData(hostRdData),
    .cfgRdata(cfgRdata), .regsQ(regsQ), .regWrStb(regWrStb), .regRdStb(regRdStb)
  );
endmodule

// File: rtl/idp_chk.sv
module idp_chk
  import idp_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [7:0]            addrLo,
  input logic                  ioWr,
  input logic [7:0]            ioWdata,
  input logic                  hostAck,
  input logic                  runAccessEn,
  input logic                  cfgMode,
  input logic                  cfgWr,
  input logic [NUM_REGS*8-1:0] regsQ,
  input logic [NUM_REGS-1:0]   regWrStb,
  input logic [7:0]            indexQ,
  input logic [7:0]            pendingBase,
  input logic [7:0]            activeBase
);
  // R2
  ack_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> (addrLo == activeBase || addrLo == 8'(activeBase + 8'd1)));

  // R3
  off_noack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runAccessEn |-> !hostAck);

  // R3
  off_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runAccessEn && !(cfgMode && cfgWr)) |-> (regWrStb == '0));

  // R4
  index_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && hostAck && addrLo == activeBase) |=> (indexQ == $past(ioWdata)));

  // R8
  pend_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendingBase == 8'hE0 || pendingBase == 8'hE2 ||
     pendingBase == 8'hE4 || pendingBase == 8'hEA));

  // R9
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(cfgMode) |=> $stable(activeBase));

  // R10
  two_writers_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(regWrStb) <= 2);

  // R11
  store_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrStb == '0) |=> $stable(regsQ));
endmodule

bind idx_data_port idp_chk u_chk (
  .clk(clk), .rstN(rstN), .addrLo(ioAddr[7:0]), .ioWr(ioWr), .ioWdata(ioWdata),
  .hostAck(hostAck), .runAccessEn(runAccessEn), .cfgMode(cfgMode), .cfgWr(cfgWr),
  .regsQ(regsQ), .regWrStb(regWrStb), .indexQ(u_ctrl.indexQ),
  .pendingBase(u_ctrl.pendingBase), .activeBase(u_ctrl.activeBase)
);

// File: tb/idx_data_port_tb.sv
module idx_data_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  hostRdData;
  logic        hostAck;
  logic        runAccessEn = 1'b1;
  logic        cfgMode = 1'b0, cfgWr = 1'b0, cfgRd = 1'b0;
  logic [7:0]  cfgAddr = '0, cfgWdata = '0;
  logic [7:0]  cfgRdata;
  logic [63:0] regsQ;
  logic [7:0]  regWrStb, regRdStb;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [8];
  logic [7:0] lastIdx;
  logic [7:0] curBase;

  always #4 clk = ~clk;

  idx_data_port u_dut (.*);

  function automatic int idxSlot(logic [7:0] v);
    case (v)
      8'h01: return 0; 8'h03: return 1; 8'h05: return 2; 8'h06: return 3;
      8'h08: return 4; 8'h09: return 5; 8'h0A: return 6; 8'h0B: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int cfgSlot(logic [7:0] v);
    case (v)
      8'hF6: return 0; 8'hF4: return 1; 8'hF9: return 2; 8'hFA: return 3;
      8'hB0: return 4; 8'hB1: return 5; 8'hB2: return 6; 8'hB3: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk); ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk); ioWr = 1'b0;
  endtask

  task automatic ioRead(logic [15:0] a, output logic [7:0] d, output logic ack);
    @(negedge clk); ioAddr = a; ioRd = 1'b1;
    #1; d = hostRdData; ack = hostAck;
    @(negedge clk); ioRd = 1'b0;
  endtask

  task automatic cfgWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cfgAddr = a; cfgWdata = d; cfgWr = 1'b1;
    @(negedge clk); cfgWr = 1'b0;
  endtask

  task automatic cfgRead(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfgAddr = a; cfgRd = 1'b1;
    #1; d = cfgRdata;
    @(negedge clk); cfgRd = 1'b0;
  endtask

  task automatic relocate(logic [7:0] nb);
    logic [7:0] d; logic a; logic [7:0] expBase;
    expBase = (nb == 8'hE0 || nb == 8'hE2 || nb == 8'hE4 || nb == 8'hEA) ? nb : curBase;
    @(negedge clk); cfgMode = 1'b1;
    cfgWrite(8'hEC, nb);
    cfgRead(8'hEC, d);
    chk("R8 pending base readback", d, expBase);
    ioRead({8'h00, curBase}, d, a);
    chk("R9 old base acks in config mode", a, 1);
    chk("R9 old base data in config mode", d, lastIdx);
    @(negedge clk); cfgMode = 1'b0; ioAddr = {8'h00, curBase}; ioRd = 1'b1;
    #1; chk("R9 old base in exit cycle", hostAck, 1);
    @(negedge clk); ioAddr = {8'h00, expBase};
    #1; chk("R9 new base acks", hostAck, 1);
    chk("R9 new base index data", hostRdData, lastIdx);
    if (expBase != curBase) begin
      ioAddr = {8'h00, curBase};
      #1; chk("R9 old base dropped", hostAck, 0);
    end
    @(negedge clk); ioRd = 1'b0;
    curBase = expBase;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic a;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    lastIdx = 8'h00; curBase = 8'hEA;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    chk("R1 registers zero", regsQ, 64'h0);
    ioRead(16'h00EA, d, a);
    chk("R1 index zero at 0xEA", {a, d}, {1'b1, 8'h00});
    @(negedge clk); cfgMode = 1'b1;
    cfgRead(8'hEC, d);
    chk("R1 pending base", d, 8'hEA);
    @(negedge clk); cfgMode = 1'b0;

    // R2 decode sweep with index 0x5A
    ioWrite(16'h00EA, 8'h5A); lastIdx = 8'h5A;
    for (int ad = 8'hD0; ad <= 8'hFF; ad++) begin
      logic eAck; logic [7:0] eD;
      ioRead(16'(ad), d, a);
      eAck = (ad == 8'hEA) || (ad == 8'hEB);
      eD = (ad == 8'hEA) ? 8'h5A : 8'h00;
      chk($sformatf("R2 decode ack %0h", ad), a, eAck);
      chk($sformatf("R2 decode data %0h / R4 index read", ad), d, eD);
    end
    ioRead(16'h01EA, d, a);
    chk("R2 upper address bit blocks", {a, d}, 9'h0);

    // R5/R6 index sweep
    for (int ix = 0; ix < 256; ix++) begin
      logic [7:0] v; int s;
      v = 8'(ix) ^ 8'hA5; s = idxSlot(8'(ix));
      ioWrite(16'h00EA, 8'(ix)); lastIdx = 8'(ix);
      ioWrite(16'h00EB, v);
      if (s >= 0) model[s] = v;
      ioRead(16'h00EB, d, a);
      if (s >= 0) chk($sformatf("R5 slot via index %0h", ix), {a, d}, {1'b1, v});
      else chk($sformatf("R6 unmapped index %0h", ix), {a, d}, {1'b1, 8'h00});
    end
    for (int s = 0; s < 8; s++)
      chk($sformatf("R6 R11 regsQ slot %0d", s), regsQ[s*8 +: 8], model[s]);

    // R7 configuration window
    @(negedge clk); cfgMode = 1'b1;
    for (int o = 0; o < 256; o++) begin
      int s; s = cfgSlot(8'(o));
      cfgRead(8'(o), d);
      if (s >= 0) chk($sformatf("R7 cfg offset %0h", o), d, model[s]);
      else if (o != 8'hEC) chk($sformatf("R7 unmapped cfg %0h", o), d, 8'h00);
    end
    cfgWrite(8'hB2, 8'h3C); model[6] = 8'h3C;
    @(negedge clk); cfgMode = 1'b0;
    ioWrite(16'h00EA, 8'h0A); lastIdx = 8'h0A;
    ioRead(16'h00EB, d, a);
    chk("R7 cfg write seen at index 0x0A", d, 8'h3C);
    cfgWrite(8'hB2, 8'h77);
    cfgRead(8'hB2, d);
    chk("R7 cfg read outside mode", d, 8'h00);
    chk("R7 cfg write outside mode ignored", regsQ[6*8 +: 8], 8'h3C);

    // R11 strobes
    @(negedge clk); ioAddr = 16'h00EB; ioRd = 1'b1;
    #1; chk("R11 read strobe slot 6", regRdStb, 8'h40);
    chk("R11 no write strobe on read", regWrStb, 8'h00);
    @(negedge clk); ioRd = 1'b0; ioWr = 1'b1; ioWdata = 8'hC3;
    #1; chk("R11 write strobe slot 6", regWrStb, 8'h40);
    @(negedge clk); ioWr = 1'b0; model[6] = 8'hC3;
    chk("R5 data write lands", regsQ[6*8 +: 8], 8'hC3);

    // R3 run access disabled
    ioWrite(16'h00EA, 8'h01); lastIdx = 8'h01;
    @(negedge clk); runAccessEn = 1'b0;
    ioWrite(16'h00EA, 8'h03);
    ioWrite(16'h00EB, 8'h99);
    ioRead(16'h00EA, d, a);
    chk("R3 no ack when disabled", {a, d}, 9'h0);
    ioRead(16'h00EB, d, a);
    chk("R3 data port silent when disabled", {a, d}, 9'h0);
    @(negedge clk); runAccessEn = 1'b1;
    ioRead(16'h00EA, d, a);
    chk("R3 index unchanged", d, 8'h01);
    ioRead(16'h00EB, d, a);
    chk("R3 register unchanged", d, model[0]);

    // R10 simultaneous writes (index 0x01 -> slot 0)
    @(negedge clk); cfgMode = 1'b1;
    @(negedge clk);
    ioAddr = 16'h00EB; ioWdata = 8'h11; ioWr = 1'b1;
    cfgAddr = 8'hF6; cfgWdata = 8'h22; cfgWr = 1'b1;
    #1; chk("R10 R11 same-slot strobe", regWrStb, 8'h01);
    @(negedge clk); ioWr = 1'b0; cfgWr = 1'b0; model[0] = 8'h22;
    chk("R10 config wins same slot", regsQ[7:0], 8'h22);
    @(negedge clk);
    ioWdata = 8'h44; ioWr = 1'b1;
    cfgAddr = 8'hF4; cfgWdata = 8'h55; cfgWr = 1'b1;
    #1; chk("R10 R11 two-slot strobe", regWrStb, 8'h03);
    @(negedge clk); ioWr = 1'b0; cfgWr = 1'b0; model[0] = 8'h44; model[1] = 8'h55;
    chk("R10 both slots written", regsQ[15:0], 16'h5544);
    @(negedge clk); cfgMode = 1'b0;

    // R8/R9 relocation through all bases and one illegal value
    relocate(8'hE0);
    relocate(8'hE2);
    relocate(8'hE6);
    relocate(8'hE4);
    relocate(8'hEA);
    ioWrite(16'h00E4, 8'h09);
    ioRead(16'h00EA, d, a);
    chk("R9 final base index unaffected by stale address", d, lastIdx);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule